// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external 128K x 8 asynchronous static RAM. The host offers single-beat requests on a valid/ready port: a 17-bit address, a write flag and a byte of write data. The controller turns each request into select, write-strobe and output-strobe waveforms that meet the memory's timing. It returns read data with a one-cycle valid pulse. The memory's bidirectional data bus appears as three split signals: data out, data in and a drive enable.

Every timing constraint is a nanosecond parameter. Each is converted to a cycle count as the ceiling of the value divided by `CLK_PERIOD_NS`, with a floor of one cycle. The memory is enabled only when its active-low select is low and its active-high select is high. The write strobe and the output strobe are never low together.

The state machine has five states:
- `ST_IDLE`: ready is high. An accepted request (the *accept* transition) registers address, data and direction, and moves to `ST_SETUP`.
- `ST_SETUP`: one cycle with the selects active and both strobes high. It always moves on to `ST_ACCESS` (the *strobe* transition).
- `ST_ACCESS`: the write or output strobe is held low for the access count. When the count runs out, the *release* transition goes to `ST_HOLD`.
- `ST_HOLD`: one cycle with strobes and selects inactive. Write data is still driven during a write. It always moves on to `ST_TURN` (the *quiet* transition).
- `ST_TURN`: the controller waits for the memory to stop driving the bus. When the wait ends, the *done* transition returns to `ST_IDLE`.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset the controller shows ready high, active-low select high, active-high select low, both strobes high, bus drive off and no read-data valid.
- R2: Both selects are active (active-low select 0, active-high select 1) exactly during `ST_SETUP` and `ST_ACCESS`. At every other time both are inactive, and neither strobe is ever low while the selects are inactive.
- R3: A write holds the write strobe low for WR_CYC = max(ceil(50/T), ceil(60/T), ceil(25/T)+ceil(30/T)) cycles, which is 6 at T = 10 ns. The output strobe stays high for the whole write, and the byte stored is the request's write data.
- R4: During a write the bus is driven from ceil(25/T) cycles after the write strobe falls until one cycle after it rises. That is 4 cycles at T = 10 ns, of which 3 fall before the rise. The bus is never driven while the output strobe is low.
- R5: A read holds the output strobe low for RD_CYC = max(ceil(70/T)-1, ceil(40/T), 1) cycles, which is 6 at T = 10 ns. The write strobe stays high, and the data-in byte is sampled at the end of the last output-strobe-low cycle.
- R6: Each read gives exactly one single-cycle read-data-valid pulse carrying the sampled byte. A write never gives one.
- R7: The address is registered when the request is accepted and does not change while the selects are active.
- R8: Ready is low for 1 + access count + 1 + ceil(30/T) cycles after an accepted request, which is 11 at T = 10 ns for both reads and writes. A valid request presented while ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 17 | Memory address bus |
| mem_cs1_n | output | 1 | Active-low memory select |
| mem_cs2 | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The memory model in the bench returns a junk byte unless the output strobe has been low for at least 40 ns and the select for at least 70 ns. A read access that is one cycle short therefore captures the wrong byte. The model also corrupts a stored byte unless the bus was driven for at least 30 ns before the write strobe rose. A drive window that opens late or closes early is therefore seen on read-back.

The address extremes 0 and 0x1FFFF are written and read back, so an address slice error would alias them. A write request is held valid in the middle of a busy read. A controller that accepted it early would overwrite stored data, and read-back exposes that. Ready-low counts expose a turnaround wait that was dropped or shortened.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD,
        ST_TURN
    } sram_state_e;

    // ceiling of ns / period, never below one cycle
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= cap_en;
            if (cap_en)
                rdata <= din;
        end
    end

    // R6: a valid pulse lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_WP_NS       = 50,
    parameter int T_CW_NS       = 60,
    parameter int T_DW_NS       = 30,
    parameter int T_WHZ_NS      = 25,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 40,
    parameter int T_HZ_NS       = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int WHZ_CYC  = ns_to_cyc(T_WHZ_NS, CLK_PERIOD_NS);
    localparam int WR_CYC   = max2(max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                        ns_to_cyc(T_CW_NS, CLK_PERIOD_NS)),
                                   WHZ_CYC + ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
    localparam int RD_CYC   = max2(max2(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS) - 1, 1),
                                   ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
    localparam int TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC  = max2(max2(WR_CYC, RD_CYC), TURN_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    sram_state_e state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              is_wr_q;
    logic              accept;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_load_val;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_done;
    logic              cap_en;

    assign accept = req_valid && req_ready;

    sram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .cnt      (cnt),
        .done     (cnt_done)
    );

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            is_wr_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                is_wr_q <= req_write;
            end
        end
    end

    // next state and wait loading
    always_comb begin
        state_nx     = state;
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_SETUP;
            ST_SETUP: begin
                state_nx     = ST_ACCESS;
                cnt_load     = 1'b1;
                cnt_load_val = is_wr_q ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
            end
            ST_ACCESS: if (cnt_done) state_nx = ST_HOLD;
            ST_HOLD: begin
                state_nx     = ST_TURN;
                cnt_load     = 1'b1;
                cnt_load_val = CNT_W'(TURN_CYC - 1);
            end
            ST_TURN:   if (cnt_done) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        mem_cs1_n = 1'b1;
        mem_cs2   = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_SETUP: begin
                mem_cs1_n = 1'b0;
                mem_cs2   = 1'b1;
            end
            ST_ACCESS: begin
                mem_cs1_n = 1'b0;
                mem_cs2   = 1'b1;
                if (is_wr_q) begin
                    mem_we_n  = 1'b0;
                    mem_dq_oe = (cnt < CNT_W'(WR_CYC - WHZ_CYC));
                end else begin
                    mem_oe_n  = 1'b0;
                end
            end
            ST_HOLD:  mem_dq_oe = is_wr_q;
            ST_TURN:  ;
            default:  ;
        endcase
    end

    assign cap_en     = (state == ST_ACCESS) && !is_wr_q && cnt_done;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_dq_in),
        .rdata  (rsp_rdata),
        .rvalid (rsp_valid)
    );

    // R4: no drive while the memory may be outputting
    a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    // R3: strobes never overlap
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    // R2: strobes only with the chip enabled
    a_r2_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> (!mem_cs1_n && mem_cs2));
    // R2: the two selects move together
    a_r2_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs1_n != mem_cs2);
    // R7: address frozen while selected
    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));
    // R8: bus quiet whenever a new request may be taken
    a_r8_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_dq_oe && mem_cs1_n && mem_oe_n && mem_we_n));

endmodule

// File: tb/sram_async_ctl_test.sv
module sram_async_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hA5;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sram_async_ctl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // ---------------- memory model ----------------
    logic [7:0] mem_m [logic [16:0]];
    logic [7:0] ref_m [logic [16:0]];
    int   sel_cyc = 0, oe_cyc = 0, drv_cyc = 0;
    logic we_seen = 1'b0;
    logic [7:0] pend = '0;

    function automatic logic [7:0] mem_rd(input logic [16:0] a);
        return mem_m.exists(a) ? mem_m[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        sel_cyc <= (!mem_cs1_n && mem_cs2) ? sel_cyc + 1 : 0;
        oe_cyc  <= (!mem_oe_n && !mem_cs1_n && mem_cs2) ? oe_cyc + 1 : 0;
        if (!mem_we_n && !mem_cs1_n && mem_cs2) begin
            we_seen <= 1'b1;
            if (mem_dq_oe) begin
                pend    <= mem_dq_out;
                drv_cyc <= drv_cyc + 1;
            end
        end else if (we_seen) begin
            mem_m[mem_addr] = (drv_cyc >= 3) ? pend : ~pend;
            we_seen <= 1'b0;
            drv_cyc <= 0;
        end
    end

    // data valid only once 40 ns of output strobe and 70 ns of select elapse
    always @(negedge clk) begin
        if (!mem_oe_n && !mem_cs1_n && mem_cs2 && oe_cyc >= 3 && sel_cyc >= 6)
            mem_dq_in <= mem_rd(mem_addr);
        else
            mem_dq_in <= 8'hA5;
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int o_busy, o_we, o_oe, o_dq, o_dq_early, o_rsp, o_bad_sel, o_bad_addr;
    logic [7:0] o_rdata;

    task automatic do_op(input logic wr, input logic [16:0] a, input logic [7:0] d,
                         input logic inject);
        o_busy = 0; o_we = 0; o_oe = 0; o_dq = 0; o_dq_early = 0;
        o_rsp = 0; o_bad_sel = 0; o_bad_addr = 0; o_rdata = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (req_ready) break;
            o_busy++;
            if (!mem_we_n) o_we++;
            if (!mem_oe_n) o_oe++;
            if (mem_dq_oe) o_dq++;
            if (mem_dq_oe && !mem_we_n) o_dq_early++;
            if (rsp_valid) begin o_rsp++; o_rdata = rsp_rdata; end
            if (mem_cs1_n == mem_cs2) o_bad_sel++;
            if ((!mem_we_n || !mem_oe_n) && mem_cs1_n) o_bad_sel++;
            if (!mem_cs1_n && mem_addr != a) o_bad_addr++;
            if (inject && i == 2) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = 17'h0A5A5; req_wdata = 8'h11;
            end
            if (inject && i == 7) req_valid = 1'b0;
            @(negedge clk);
        end
        if (wr) ref_m[a] = d;
    endtask

    task automatic run_op(input logic wr, input logic [16:0] a, input logic [7:0] d,
                          input logic inject);
        logic [7:0] exp;
        exp = ref_m.exists(a) ? ref_m[a] : 8'h00;
        do_op(wr, a, d, inject);
        chk("R8 busy cycles", o_busy, 11);
        chk("R2 select polarity", o_bad_sel, 0);
        chk("R7 address held", o_bad_addr, 0);
        if (wr) begin
            chk("R3 write strobe width", o_we, 6);
            chk("R3 output strobe high in write", o_oe, 0);
            chk("R4 drive window", o_dq, 4);
            chk("R4 drive before strobe rise", o_dq_early, 3);
            chk("R6 no valid on write", o_rsp, 0);
        end else begin
            chk("R5 output strobe width", o_oe, 6);
            chk("R5 write strobe high in read", o_we, 0);
            chk("R6 single valid pulse", o_rsp, 1);
            chk("R5 R6 read data", o_rdata, exp);
        end
    endtask

    // {write, addr, data}
    localparam logic [25:0] VEC [11] = '{
        {1'b1, 17'h00000, 8'h3C},
        {1'b1, 17'h1FFFF, 8'hC3},
        {1'b1, 17'h0A5A5, 8'h5A},
        {1'b0, 17'h00000, 8'h00},
        {1'b0, 17'h1FFFF, 8'h00},
        {1'b0, 17'h0A5A5, 8'h00},
        {1'b1, 17'h00000, 8'hFF},
        {1'b0, 17'h00000, 8'h00},
        {1'b0, 17'h12345, 8'h00},
        {1'b1, 17'h12345, 8'h81},
        {1'b0, 17'h12345, 8'h00}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", req_ready, 1);
        chk("R1 cs1_n", mem_cs1_n, 1);
        chk("R1 cs2", mem_cs2, 0);
        chk("R1 we_n", mem_we_n, 1);
        chk("R1 oe_n", mem_oe_n, 1);
        chk("R1 dq_oe", mem_dq_oe, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 11; k++)
            run_op(VEC[k][25], VEC[k][24:8], VEC[k][7:0], 1'b0);

        // R8: a write offered during a busy read must be ignored
        run_op(1'b0, 17'h1FFFF, 8'h00, 1'b1);
        run_op(1'b0, 17'h0A5A5, 8'h00, 1'b0);
        chk("R8 ignored request left data", o_rdata, 8'h5A);

        // back-to-back: write then immediate read of the same byte
        run_op(1'b1, 17'h00001, 8'h96, 1'b0);
        run_op(1'b0, 17'h00001, 8'h00, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule